// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block collects the interrupt causes of a 16550-style serial port and turns them into one prioritised identification byte plus an interrupt request line. Each cause has its own pending latch with its own set and clear rules. The clear rules come from CPU register accesses: a read of the identification, line-status, modem-status or receive-buffer register, a write of the transmit register, and a receive-FIFO flush. The receive and transmit datapaths are outside the block. They supply only the status levels and pulses described below.

The block carries no data stream, so it has no valid/ready handshake. Every strobe and event input is a single-cycle pulse sampled on the rising clock edge, and the block never stalls the CPU. A pending latch updates on the edge where its inputs are sampled. The identification byte and the request line are combinational from the latches, so they show the new state right after that edge. Bit 0 of the identification byte is active low: 0 means something is pending. Bits 3:1 carry the cause code. Bit 4 mirrors the autobaud-lock status and takes no part in the priority.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, and whenever no enabled cause is pending, `iir[3:0]` reads 4'b0001 and `irq` is low.
- R2: Any bit of `line_err` sets the line-status cause, which reports code 4'b0110. `rd_lsr` clears it. If a new error arrives in the same cycle as `rd_lsr`, the cause stays pending.
- R3: When `fifo_mode` is 0, a low-to-high transition of `rx_lvl` (buffer full) sets the receive-data cause, which reports code 4'b0100. `rd_rbr` clears it.
- R4: When `fifo_mode` is 1, the receive-data cause follows `rx_lvl` (at or above threshold) one edge later. `rx_flush` clears it on that edge even while `rx_lvl` stays high.
- R5: The character-timeout cause reports code 4'b1100. It is set by `rx_tout` only while `fifo_mode` is 1. `rd_rbr` or `rx_flush` clears it. It is forced clear while `fifo_mode` is 0. It ranks just below the receive-data cause.
- R6: A low-to-high transition of `tx_room` sets the transmit cause, which reports code 4'b0010. `wr_thr` clears it. A `tx_room` level that is already high when reset ends raises nothing.
- R7: `rd_iir` clears the transmit cause only when `iir[3:0]` reads 4'b0010 in the cycle of the read. Otherwise the transmit cause stays pending.
- R8: `msr_chg` sets the modem cause, which reports code 4'b0000. `rd_msr` clears it.
- R9: The reported cause follows the order line status > receive data > timeout > transmit > modem. Clearing the reported cause exposes the next one down.
- R10: `src_en` masks what is reported: bit 0 covers receive data and timeout, bit 1 transmit, bit 2 line status, bit 3 modem. A masked cause keeps its latch and is reported once it is unmasked. `irq` is high exactly when `iir[0]` is 0.
- R11: `iir[4]` equals `abl_lock` and `iir[7:5]` read 0. Neither changes `irq` or the reported code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_mode | input | 1 | 1 = FIFO mode, 0 = single-byte mode |
| line_err | input | NERR | Error pulses: overrun, parity, framing, break |
| rx_lvl | input | 1 | Receive buffer full (single-byte mode) or FIFO at/above threshold (FIFO mode) |
| rx_tout | input | 1 | Character-timeout pulse |
| rx_flush | input | 1 | Receive-FIFO reset pulse |
| tx_room | input | 1 | Holding register empty or transmit FIFO half full or less |
| msr_chg | input | 1 | Modem-line change pulse |
| abl_lock | input | 1 | Autobaud circuit has set the divisor |
| src_en | input | 4 | Per-cause report enables |
| rd_iir | input | 1 | Identification register read strobe |
| rd_lsr | input | 1 | Line-status register read strobe |
| rd_rbr | input | 1 | Receive buffer / FIFO read strobe |
| rd_msr | input | 1 | Modem-status register read strobe |
| wr_thr | input | 1 | Transmit register / FIFO write strobe |
| iir | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request, active high |

## Verification
Any wrong latch or a wrong clear rule shows up on `iir[3:0]` no later than one edge after the stimulus. It appears as a missing code, a stale code, or the wrong cause winning. Keeping several causes pending at once and peeling them off one read at a time exposes priority errors and clear rules applied to the wrong cause. The conditional transmit clear on an identification read is the subtle case. It is caught by reading while a higher cause hides the transmit cause, then checking that the transmit code appears once that cause is gone.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  // Cause index order is the priority order: index 0 wins.
  localparam int NSRC = 5;
  localparam int SRC_LINE = 0;
  localparam int SRC_RXD  = 1;
  localparam int SRC_TOUT = 2;
  localparam int SRC_TXR  = 3;
  localparam int SRC_MDM  = 4;

  localparam int CODE_W = 4;
  localparam logic [CODE_W-1:0] CODE_IDLE = 4'b0001;

  function automatic logic [CODE_W-1:0] code_of(input int idx);
    case (idx)
      SRC_LINE: code_of = 4'b0110;
      SRC_RXD:  code_of = 4'b0100;
      SRC_TOUT: code_of = 4'b1100;
      SRC_TXR:  code_of = 4'b0010;
      default:  code_of = 4'b0000;
    endcase
  endfunction
endpackage

// File: rtl/irq_rise_det.sv
module irq_rise_det #(
  parameter logic RST_LVL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_LVL;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] kill,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  // Per cause: kill beats set, set beats clear.
  for (genvar i = 0; i < N; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pend[i] <= 1'b0;
      else if (kill[i]) pend[i] <= 1'b0;
      else if (set[i])  pend[i] <= 1'b1;
      else if (clr[i])  pend[i] <= 1'b0;
    end

    p_kill_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      kill[i] |=> !pend[i]);
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import uart_irq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0]      req,
  output logic [CODE_W-1:0] code
);
  always_comb begin
    code = CODE_IDLE;
    // Walk from lowest to highest priority so the smallest index wins.
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) code = code_of(i);
    end
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int NERR = 4,
  parameter int IIR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_mode,
  input  logic [NERR-1:0]  line_err,
  input  logic             rx_lvl,
  input  logic             rx_tout,
  input  logic             rx_flush,
  input  logic             tx_room,
  input  logic             msr_chg,
  input  logic             abl_lock,
  input  logic [3:0]       src_en,
  input  logic             rd_iir,
  input  logic             rd_lsr,
  input  logic             rd_rbr,
  input  logic             rd_msr,
  input  logic             wr_thr,
  output logic [IIR_W-1:0] iir,
  output logic             irq
);
  localparam int ABL_BIT = CODE_W;
  localparam int PAD_W = IIR_W - CODE_W - 1;

  logic rx_rise, tx_rise;
  logic [NSRC-1:0] kill, set, clr, pend, en_mask, req;
  logic [CODE_W-1:0] code;

  irq_rise_det #(.RST_LVL(1'b0)) u_rx_rise (
    .clk(clk), .rst_n(rst_n), .lvl(rx_lvl), .rise(rx_rise));

  // Reset level high: a transmitter that is idle out of reset raises nothing.
  irq_rise_det #(.RST_LVL(1'b1)) u_tx_rise (
    .clk(clk), .rst_n(rst_n), .lvl(tx_room), .rise(tx_rise));

  always_comb begin
    kill = '0;
    set  = '0;
    clr  = '0;

    set[SRC_LINE] = |line_err;
    clr[SRC_LINE] = rd_lsr;

    if (fifo_mode) begin
      kill[SRC_RXD] = rx_flush;
      set[SRC_RXD]  = rx_lvl;
      clr[SRC_RXD]  = ~rx_lvl;
    end else begin
      set[SRC_RXD]  = rx_rise;
      clr[SRC_RXD]  = rd_rbr;
    end

    kill[SRC_TOUT] = ~fifo_mode | rx_flush;
    set[SRC_TOUT]  = rx_tout;
    clr[SRC_TOUT]  = rd_rbr;

    // The identification read clears the transmit cause only when the
    // byte being read reports it in this same cycle.
    set[SRC_TXR] = tx_rise;
    clr[SRC_TXR] = wr_thr | (rd_iir & (code == code_of(SRC_TXR)));

    set[SRC_MDM] = msr_chg;
    clr[SRC_MDM] = rd_msr;
  end

  irq_pend_bank #(.N(NSRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .kill(kill), .set(set), .clr(clr), .pend(pend));

  always_comb begin
    en_mask = '0;
    en_mask[SRC_LINE] = src_en[2];
    en_mask[SRC_RXD]  = src_en[0];
    en_mask[SRC_TOUT] = src_en[0];
    en_mask[SRC_TXR]  = src_en[1];
    en_mask[SRC_MDM]  = src_en[3];
  end

  assign req = pend & en_mask;

  irq_prio_enc #(.N(NSRC)) u_enc (.req(req), .code(code));

  assign iir = {{PAD_W{1'b0}}, abl_lock, code};
  assign irq = ~code[0];

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |-> (iir[3:0] == 4'b0001 && !irq));
  p_line_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[SRC_LINE] && src_en[2]) |-> (iir[3:0] == 4'b0110));
  p_lsr_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lsr && !(|line_err)) |=> !pend[SRC_LINE]);
  p_tout_fifo_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode |=> (iir[3] == 1'b0));
  p_tx_read_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_iir && iir[3:0] == 4'b0010 && !tx_rise) |=> !pend[SRC_TXR]);
  p_irq_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($countones(req) > 0));
  p_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && rx_flush) |=> !pend[SRC_RXD]);
endmodule

// File: tb/sim_uart_irq_ident.sv
module sim_uart_irq_ident;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_mode = 1'b0;
  logic [3:0] line_err = '0;
  logic rx_lvl = 1'b0, rx_tout = 1'b0, rx_flush = 1'b0, tx_room = 1'b0;
  logic msr_chg = 1'b0, abl_lock = 1'b0;
  logic [3:0] src_en = 4'hF;
  logic rd_iir = 1'b0, rd_lsr = 1'b0, rd_rbr = 1'b0, rd_msr = 1'b0, wr_thr = 1'b0;
  logic [7:0] iir;
  logic irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  uart_irq_ident u0 (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .line_err(line_err),
    .rx_lvl(rx_lvl), .rx_tout(rx_tout), .rx_flush(rx_flush), .tx_room(tx_room),
    .msr_chg(msr_chg), .abl_lock(abl_lock), .src_en(src_en), .rd_iir(rd_iir),
    .rd_lsr(rd_lsr), .rd_rbr(rd_rbr), .rd_msr(rd_msr), .wr_thr(wr_thr),
    .iir(iir), .irq(irq));

  // Driver: one clock edge, queue the expectation, then drop all pulses.
  task automatic tick(input logic [7:0] exp, input string tag);
    @(posedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    #1;
    line_err = '0; rx_tout = 0; rx_flush = 0; msr_chg = 0;
    rd_iir = 0; rd_lsr = 0; rd_rbr = 0; rd_msr = 0; wr_thr = 0;
  endtask

  // Monitor: compare at the falling edge, before the driver moves inputs.
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (iir !== e || irq !== ~e[0]) begin
        bad++;
        $display("FAIL %s: iir=%h irq=%b expected iir=%h irq=%b", t, iir, irq, e, ~e[0]);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    rst_n = 1'b1;
    tick(8'h01, "R1 reset idle");

    // R2 line status
    line_err = 4'b0100; tick(8'h06, "R2 error sets");
    rd_lsr = 1;         tick(8'h01, "R2 lsr read clears");
    line_err = 4'b0001; tick(8'h06, "R2 error sets again");
    rd_lsr = 1; line_err = 4'b0010; tick(8'h06, "R2 new error beats clear");
    rd_lsr = 1;         tick(8'h01, "R2 clear");

    // R3 single-byte receive
    rx_lvl = 1; tick(8'h04, "R3 buffer full");
    rd_rbr = 1; tick(8'h01, "R3 rbr read clears");
    rx_lvl = 0; tick(8'h01, "R3 no rise");

    // R6 transmit
    tx_room = 1; tick(8'h02, "R6 tx room rises");
    wr_thr = 1;  tick(8'h01, "R6 write clears");
    tick(8'h01, "R6 level alone does not re-raise");
    tx_room = 0; tick(8'h01, "R6 idle");

    // R7 conditional clear by identification read
    tx_room = 1; tick(8'h02, "R7 tx pending");
    rd_iir = 1;  tick(8'h01, "R7 read while reported clears");
    tx_room = 0; tick(8'h01, "R7 idle");
    tx_room = 1; line_err = 4'b1000; tick(8'h06, "R7 line hides tx");
    rd_iir = 1;  tick(8'h06, "R7 read while hidden");
    rd_lsr = 1;  tick(8'h02, "R7 tx survived hidden read");
    wr_thr = 1;  tick(8'h01, "R7 cleanup");
    tx_room = 0; tick(8'h01, "R7 idle");

    // R8 modem
    msr_chg = 1; tick(8'h00, "R8 modem sets");
    rd_msr = 1;  tick(8'h01, "R8 msr read clears");

    // R9 priority ladder
    msr_chg = 1; tx_room = 1; rx_lvl = 1; line_err = 4'b0001;
    tick(8'h06, "R9 line first");
    rd_lsr = 1; tick(8'h04, "R9 rx data next");
    rd_rbr = 1; tick(8'h02, "R9 tx next");
    wr_thr = 1; tick(8'h00, "R9 modem last");
    rd_msr = 1; tick(8'h01, "R9 empty");
    rx_lvl = 0; tx_room = 0; tick(8'h01, "R9 idle");

    // R5 timeout ignored outside FIFO mode
    rx_tout = 1; tick(8'h01, "R5 timeout ignored in single-byte mode");
    fifo_mode = 1; tick(8'h01, "R4 fifo mode idle");

    // R4 FIFO receive threshold
    rx_lvl = 1; tick(8'h04, "R4 threshold reached");
    tick(8'h04, "R4 level holds");
    rx_lvl = 0; tick(8'h01, "R4 below threshold clears");
    rx_lvl = 1; tick(8'h04, "R4 threshold again");
    rx_flush = 1; tick(8'h01, "R4 flush clears");
    tick(8'h04, "R4 level re-asserts");
    rx_lvl = 0; tick(8'h01, "R4 idle");

    // R5 timeout in FIFO mode
    rx_tout = 1; tick(8'h0C, "R5 timeout sets");
    rd_rbr = 1;  tick(8'h01, "R5 read clears");
    rx_tout = 1; tick(8'h0C, "R5 timeout again");
    rx_lvl = 1;  tick(8'h04, "R5 rx data outranks timeout");
    rx_lvl = 0;  tick(8'h0C, "R5 timeout exposed");
    rx_flush = 1; tick(8'h01, "R5 flush clears");
    rx_tout = 1; tick(8'h0C, "R5 timeout set");
    fifo_mode = 0; tick(8'h01, "R5 leaving fifo mode clears");
    fifo_mode = 1; tick(8'h01, "R5 stays clear");

    // R10 enables
    src_en = 4'h0; line_err = 4'b0001; tick(8'h01, "R10 masked line");
    src_en = 4'b0100; tick(8'h06, "R10 unmasked line");
    src_en = 4'hF; rd_lsr = 1; tick(8'h01, "R10 cleanup");
    src_en = 4'b1101; tx_room = 1; tick(8'h01, "R10 masked tx");
    rd_iir = 1; tick(8'h01, "R10 read while tx masked");
    src_en = 4'hF; tick(8'h02, "R10 masked tx kept its latch");
    wr_thr = 1; tx_room = 0; tick(8'h01, "R10 cleanup");

    // R11 autobaud lock bit
    abl_lock = 1; tick(8'h11, "R11 lock bit alone");
    line_err = 4'b0100; tick(8'h16, "R11 lock with line");
    rd_lsr = 1; tick(8'h11, "R11 lock after clear");
    abl_lock = 0; tick(8'h01, "R11 idle");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule